// File: doc/BRIEF.md
# Snooping Invalidation Cache Controller

This block is a write-back cache controller for one processor among several that share a single bus. It keeps its copy of memory coherent with the others through an invalidation protocol. Each line of a small direct-mapped cache holds a tag, one data word and one of three states:

- invalid: the line holds no usable data.
- shared: the line agrees with memory, and other caches may hold it too.
- exclusive: the line holds the only correct copy, and memory may be out of date.

A processor access that can be served locally completes without touching the bus. Any other access raises a bus request, waits for a one-bit grant from an arbiter, and then runs a read-miss, write-miss or write-back transaction. A write-back is issued only when an exclusive victim has to leave.

The controller also watches the misses that other caches put on the bus. When one of them reaches a line held here, the line is downgraded or dropped. If that line was exclusive, its data is pushed out on a flush port in the cycle after the snooped miss.

A bus transaction is one grant cycle. In that cycle memory supplies `bus_rdata` for a miss and accepts `bus_wdata` for a write-back. Only one transaction is on the bus at a time, so a grant to this controller never falls in the same cycle as a snooped transaction.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After synchronous reset every line is invalid, and `cpu_ready`, `bus_req` and `flush_valid` are low, so the first access to any address misses.
- R2: A processor read to a shared or exclusive line with a matching tag, or a processor write to an exclusive line with a matching tag, pulses `cpu_ready` for one cycle with no bus request. A read returns the line's word; a write replaces it.
- R3: A processor read that misses requests the bus with command 1 (read-miss) and the full request address. On the grant it fills the line from `bus_rdata`, sets the line to shared and returns that word.
- R4: A processor write to a line that is not exclusive (a miss, or a tag hit in shared) requests the bus with command 2 (write-miss). On the grant the line becomes exclusive and holds the write data.
- R5: When a miss needs a line frame whose current line is exclusive under another tag, a write-back (command 3) carrying the victim's address and data is granted first, and the frame becomes invalid. A shared or invalid victim is replaced with no write-back.
- R6: A snooped read-miss (`snp_cmd` 1) to a line held exclusive raises `flush_valid` in the next cycle, with that address and the line's data, and the line becomes shared.
- R7: A snooped write-miss (`snp_cmd` 2) to a line held shared or exclusive makes it invalid. A flush happens as in R6 only if the line was exclusive.
- R8: A snooped transaction whose tag differs, that targets an invalid line, or that is a snooped read-miss to a shared line, changes no state and gives no flush.
- R9: While a bus transaction is needed, `cpu_ready` stays low. `bus_req` stays high with stable command and address until `bus_gnt`, and drops in the cycle after the grant.
- R10: If a snooped miss hits the victim line while its write-back is still waiting for a grant, the write-back is withdrawn. The snoop's flush replaces it, and the controller continues from the victim's new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_cmd | output | 2 | 1 read-miss, 2 write-miss, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_rdata | input | DATA_W | Memory data for a granted miss |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| flush_valid | output | 1 | Exclusive data is being supplied for a snoop |
| flush_addr | output | ADDR_W | Address of the flushed line |
| flush_data | output | DATA_W | Flushed data |

## Verification
The bench builds the controller with a 6-bit address, 2 index bits and 8-bit data. This gives four line frames and sixteen possible tags. Random addresses are drawn from only three tags per frame, so conflict evictions, exclusive victims and snoop hits on held lines all occur often. The small memory behind the bench also lets it model every word exactly. Directed cases cover the upgrade from shared to exclusive and snoops that miss on tag. They also cover a snoop that lands on a victim while its write-back is still waiting for the bus.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WRBACK = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/snp_line_store.sv
module snp_line_store
  import snp_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  // processor-side read port
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output line_st_t          rd_st,
  // snoop-side read port
  input  logic [IDX_W-1:0]  sp_idx,
  output logic [TAG_W-1:0]  sp_tag,
  output logic [DATA_W-1:0] sp_data,
  output line_st_t          sp_st,
  // controller write port (tag, data, state together)
  input  logic              f_we,
  input  logic [IDX_W-1:0]  f_idx,
  input  logic [TAG_W-1:0]  f_tag,
  input  logic [DATA_W-1:0] f_data,
  input  line_st_t          f_st,
  // snoop state write port (wins over the controller port)
  input  logic              s_we,
  input  line_st_t          s_st_new
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];
  line_st_t          st_q     [LINES];

  // tag and data arrays: one write port, no reset, RAM-inferable
  always_ff @(posedge clk) begin
    if (f_we) begin
      tag_mem[f_idx]  <= f_tag;
      data_mem[f_idx] <= f_data;
    end
  end

  // state bits need a reset, so each line gets its own register
  for (genvar i = 0; i < LINES; i++) begin : g_state
    localparam logic [IDX_W-1:0] LIDX = IDX_W'(i);
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[i] <= LS_INV;
      end else if (s_we && sp_idx == LIDX) begin
        st_q[i] <= s_st_new;
      end else if (f_we && f_idx == LIDX) begin
        st_q[i] <= f_st;
      end
    end
  end

  assign rd_tag  = tag_mem[rd_idx];
  assign rd_data = data_mem[rd_idx];
  assign rd_st   = st_q[rd_idx];
  assign sp_tag  = tag_mem[sp_idx];
  assign sp_data = data_mem[sp_idx];
  assign sp_st   = st_q[sp_idx];
endmodule

// File: rtl/snp_snoop_unit.sv
module snp_snoop_unit
  import snp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [IDX_W-1:0]  sp_idx,
  input  logic [ADDR_W-IDX_W-1:0] sp_tag,
  input  logic [DATA_W-1:0] sp_data,
  input  line_st_t          sp_st,
  output logic              s_we,
  output line_st_t          s_st_new,
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_addr,
  output logic [DATA_W-1:0] flush_data
);
  logic held_match;
  logic is_rd;
  logic is_wr;
  logic need_flush;

  always_comb begin
    sp_idx     = snp_addr[IDX_W-1:0];
    is_rd      = (snp_cmd == BC_RDMISS);
    is_wr      = (snp_cmd == BC_WRMISS);
    held_match = snp_valid && (sp_st != LS_INV) &&
                 (sp_tag == snp_addr[ADDR_W-1:IDX_W]);
    need_flush = held_match && (sp_st == LS_EXC) && (is_rd || is_wr);
    s_we       = held_match && (is_wr || (is_rd && sp_st == LS_EXC));
    s_st_new   = is_rd ? LS_SHR : LS_INV;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_valid <= 1'b0;
      flush_addr  <= '0;
      flush_data  <= '0;
    end else begin
      flush_valid <= need_flush;
      if (need_flush) begin
        flush_addr <= snp_addr;
        flush_data <= sp_data;
      end
    end
  end
endmodule

// File: rtl/snp_ctrl_fsm.sv
module snp_ctrl_fsm
  import snp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [ADDR_W-IDX_W-1:0] rd_tag,
  input  logic [DATA_W-1:0] rd_data,
  input  line_st_t          rd_st,
  output logic              f_we,
  output logic [IDX_W-1:0]  f_idx,
  output logic [ADDR_W-IDX_W-1:0] f_tag,
  output logic [DATA_W-1:0] f_data,
  output line_st_t          f_st
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {F_IDLE, F_DECIDE, F_WB, F_MISS} fsm_t;

  fsm_t              state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;

  logic [TAG_W-1:0]  req_tag;
  logic              snp_same_idx;
  logic              tag_hit;
  logic              local_done;
  logic              victim_dirty;

  always_comb begin
    rd_idx       = addr_q[IDX_W-1:0];
    req_tag      = addr_q[ADDR_W-1:IDX_W];
    snp_same_idx = snp_valid && (snp_addr[IDX_W-1:0] == rd_idx);
    tag_hit      = (rd_st != LS_INV) && (rd_tag == req_tag);
    local_done   = tag_hit && (!we_q || rd_st == LS_EXC);
    victim_dirty = !tag_hit && (rd_st == LS_EXC);
  end

  // array updates: write hit, write-back retire, miss fill
  always_comb begin
    f_we   = 1'b0;
    f_idx  = rd_idx;
    f_tag  = rd_tag;
    f_data = rd_data;
    f_st   = rd_st;
    unique case (state_q)
      F_DECIDE: begin
        if (!snp_same_idx && local_done && we_q) begin
          f_we   = 1'b1;
          f_data = wdata_q;
        end
      end
      F_WB: begin
        if (bus_gnt) begin
          f_we = 1'b1;
          f_st = LS_INV;
        end
      end
      F_MISS: begin
        if (bus_gnt) begin
          f_we   = 1'b1;
          f_tag  = req_tag;
          f_data = we_q ? wdata_q : bus_rdata;
          f_st   = we_q ? LS_EXC : LS_SHR;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= F_IDLE;
      addr_q    <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      bus_req   <= 1'b0;
      bus_cmd   <= BC_NONE;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (state_q)
        F_IDLE: begin
          if (cpu_req && !cpu_ready) begin
            addr_q  <= cpu_addr;
            we_q    <= cpu_we;
            wdata_q <= cpu_wdata;
            state_q <= F_DECIDE;
          end
        end
        F_DECIDE: begin
          if (!snp_same_idx) begin
            if (local_done) begin
              cpu_ready <= 1'b1;
              cpu_rdata <= rd_data;
              state_q   <= F_IDLE;
            end else if (victim_dirty) begin
              bus_req   <= 1'b1;
              bus_cmd   <= BC_WRBACK;
              bus_addr  <= {rd_tag, rd_idx};
              bus_wdata <= rd_data;
              state_q   <= F_WB;
            end else begin
              bus_req  <= 1'b1;
              bus_cmd  <= we_q ? BC_WRMISS : BC_RDMISS;
              bus_addr <= addr_q;
              state_q  <= F_MISS;
            end
          end
        end
        F_WB: begin
          if (bus_gnt || snp_same_idx) begin
            bus_req <= 1'b0;
            bus_cmd <= BC_NONE;
            state_q <= F_DECIDE;
          end
        end
        F_MISS: begin
          if (bus_gnt) begin
            bus_req   <= 1'b0;
            bus_cmd   <= BC_NONE;
            cpu_ready <= 1'b1;
            cpu_rdata <= bus_rdata;
            state_q   <= F_IDLE;
          end
        end
        default: state_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
  import snp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_addr,
  output logic [DATA_W-1:0] flush_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  rd_idx;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  line_st_t          rd_st;
  logic [IDX_W-1:0]  sp_idx;
  logic [TAG_W-1:0]  sp_tag;
  logic [DATA_W-1:0] sp_data;
  line_st_t          sp_st;
  logic              f_we;
  logic [IDX_W-1:0]  f_idx;
  logic [TAG_W-1:0]  f_tag;
  logic [DATA_W-1:0] f_data;
  line_st_t          f_st;
  logic              s_we;
  line_st_t          s_st_new;

  snp_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_data(rd_data), .rd_st(rd_st),
    .sp_idx(sp_idx), .sp_tag(sp_tag), .sp_data(sp_data), .sp_st(sp_st),
    .f_we(f_we), .f_idx(f_idx), .f_tag(f_tag), .f_data(f_data), .f_st(f_st),
    .s_we(s_we), .s_st_new(s_st_new)
  );

  snp_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .sp_idx(sp_idx), .sp_tag(sp_tag), .sp_data(sp_data), .sp_st(sp_st),
    .s_we(s_we), .s_st_new(s_st_new),
    .flush_valid(flush_valid), .flush_addr(flush_addr), .flush_data(flush_data)
  );

  snp_ctrl_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_data(rd_data), .rd_st(rd_st),
    .f_we(f_we), .f_idx(f_idx), .f_tag(f_tag), .f_data(f_data), .f_st(f_st)
  );
endmodule

// File: rtl/snp_ctrl_chk.sv
module snp_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              flush_valid,
  input logic [ADDR_W-1:0] flush_addr
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!cpu_ready && !bus_req && !flush_valid));

  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  assert_cmd_legal_R4: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_cmd != 2'd0));

  assert_flush_cause_R6: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> ($past(snp_valid) && flush_addr == $past(snp_addr)));

  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt && !snp_valid) |=>
      (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  assert_no_ready_on_bus_R9: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !cpu_ready);

  assert_grant_release_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt) |=> !bus_req);
endmodule

bind snoop_cache_ctrl snp_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .bus_req(bus_req),
  .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
  .snp_valid(snp_valid), .snp_addr(snp_addr),
  .flush_valid(flush_valid), .flush_addr(flush_addr)
);

// File: tb/snoop_cache_ctrl_tb.sv
module snoop_cache_ctrl_tb;
  localparam int AW = 6;
  localparam int IW = 2;
  localparam int DW = 8;
  localparam int NL = 1 << IW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_gnt = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          flush_valid;
  logic [AW-1:0] flush_addr;
  logic [DW-1:0] flush_data;

  always #4 clk = ~clk;

  snoop_cache_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u_dut (.*);

  int total = 0;
  int bad = 0;

  // reference model: 0 invalid, 1 shared, 2 exclusive
  int            m_st  [NL];
  logic [AW-IW-1:0] m_tag [NL];
  logic [DW-1:0] m_dat [NL];
  logic [DW-1:0] mem   [1 << AW];

  function automatic logic [AW-1:0] line_addr(int i);
    return {m_tag[i], IW'(i)};
  endfunction

  function automatic bit held(logic [AW-1:0] a);
    return m_st[a[IW-1:0]] != 0 && m_tag[a[IW-1:0]] == a[AW-1:IW];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one snooped transaction; called at a negedge
  task automatic do_snoop(logic [1:0] c, logic [AW-1:0] a);
    int i;
    bit exc;
    i = int'(a[IW-1:0]);
    exc = held(a) && m_st[i] == 2;
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    check(flush_valid == exc, c == 2'd1 ? "R6" : "R7", "flush_valid", flush_valid, exc);
    if (!exc && !flush_valid) check(1'b1, "R8", "no flush", 0, 0);
    if (exc && flush_valid) begin
      check(flush_addr == a, "R6", "flush_addr", flush_addr, a);
      check(flush_data == m_dat[i], "R7", "flush_data", flush_data, m_dat[i]);
      mem[a] = m_dat[i];
    end
    if (held(a)) begin
      if (c == 2'd2) m_st[i] = 0;
      else if (c == 2'd1 && m_st[i] == 2) m_st[i] = 1;
    end
  endtask

  // one processor access; called at a negedge
  task automatic cpu_op(bit we, logic [AW-1:0] a, logic [DW-1:0] d, bit snoop_in_wb);
    int i;
    bit hit, wb_pend, miss_pend, snp_pend, done, injected;
    logic [DW-1:0] exp_rd;
    i = int'(a[IW-1:0]);
    hit = held(a);
    miss_pend = !(hit && (!we || m_st[i] == 2));
    wb_pend = miss_pend && !hit && m_st[i] == 2;
    exp_rd = m_dat[i];
    snp_pend = 1'b0; injected = 1'b0; done = 1'b0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    for (int cyc = 0; cyc < 60 && !done; cyc++) begin
      @(negedge clk);
      if (bus_gnt) bus_gnt = 1'b0;
      if (snp_pend) begin
        snp_pend = 1'b0;
        snp_valid = 1'b0;
        check(flush_valid && flush_data == m_dat[i], "R10", "flush of waiting victim",
              flush_valid, 1);
        mem[line_addr(i)] = m_dat[i];
        m_st[i] = 0;
        wb_pend = 1'b0;
        continue;
      end
      if (cpu_ready) begin
        check(!wb_pend && !miss_pend, "R9", "ready before bus work", cpu_ready, 0);
        if (!we) check(cpu_rdata == exp_rd, hit ? "R2" : "R3", "read data", cpu_rdata, exp_rd);
        else check(1'b1, hit ? "R2" : "R4", "write done", 1, 1);
        if (we && !miss_pend) m_dat[i] = d;
        cpu_req = 1'b0;
        done = 1'b1;
      end else if (bus_req) begin
        if (wb_pend) begin
          check(bus_cmd == 2'd3 && bus_addr == line_addr(i) && bus_wdata == m_dat[i],
                "R5", "write-back", {bus_cmd, bus_addr}, {2'd3, line_addr(i)});
          if (snoop_in_wb && !injected) begin
            injected = 1'b1;
            snp_pend = 1'b1;
            snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = line_addr(i);
          end else if ($urandom_range(0, 2) != 0) begin
            bus_gnt = 1'b1;
            mem[line_addr(i)] = m_dat[i];
            m_st[i] = 0;
            wb_pend = 1'b0;
          end
        end else if (miss_pend) begin
          check(bus_cmd == (we ? 2'd2 : 2'd1) && bus_addr == a, we ? "R4" : "R3",
                "miss request", {bus_cmd, bus_addr}, {(we ? 2'd2 : 2'd1), a});
          if ($urandom_range(0, 2) != 0) begin
            bus_gnt = 1'b1;
            bus_rdata = mem[a];
            exp_rd = mem[a];
            m_tag[i] = a[AW-1:IW];
            m_st[i] = we ? 2 : 1;
            m_dat[i] = we ? d : mem[a];
            miss_pend = 1'b0;
          end
        end else begin
          check(1'b0, "R2", "unexpected bus request", bus_cmd, 0);
          bus_gnt = 1'b1;
        end
      end
    end
    if (!done) begin
      check(1'b0, "R9", "access never completed", 0, 1);
      cpu_req = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd7331));
    for (int k = 0; k < (1 << AW); k++) mem[k] = DW'(k * 37 + 11);
    for (int k = 0; k < NL; k++) begin m_st[k] = 0; m_tag[k] = '0; m_dat[k] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check(!cpu_ready && !bus_req && !flush_valid, "R1", "idle after reset",
          {cpu_ready, bus_req, flush_valid}, 0);
    @(negedge clk);

    // directed corner cases
    cpu_op(1'b0, 6'h05, 8'h00, 1'b0);   // R3 read miss
    cpu_op(1'b0, 6'h05, 8'h00, 1'b0);   // R2 read hit shared
    cpu_op(1'b1, 6'h05, 8'hA5, 1'b0);   // R4 upgrade from shared
    cpu_op(1'b1, 6'h05, 8'h5A, 1'b0);   // R2 write hit exclusive
    cpu_op(1'b0, 6'h05, 8'h00, 1'b0);   // R2 read back
    cpu_op(1'b0, 6'h15, 8'h00, 1'b0);   // R5 exclusive victim write-back
    cpu_op(1'b0, 6'h05, 8'h00, 1'b0);   // R5 shared victim silently replaced
    cpu_op(1'b1, 6'h22, 8'h3C, 1'b0);
    do_snoop(2'd1, 6'h22);              // R6 read-miss on exclusive
    cpu_op(1'b1, 6'h22, 8'hC3, 1'b0);   // R6 line now shared, write misses
    do_snoop(2'd2, 6'h22);              // R7 write-miss on exclusive
    cpu_op(1'b0, 6'h22, 8'h00, 1'b0);   // R7 line invalid, read misses
    do_snoop(2'd2, 6'h32);              // R8 tag differs
    do_snoop(2'd1, 6'h22);              // R8 read-miss on shared
    cpu_op(1'b0, 6'h22, 8'h00, 1'b0);   // R8 still a hit
    do_snoop(2'd2, 6'h22);              // R7 shared line dropped, no flush
    cpu_op(1'b0, 6'h22, 8'h00, 1'b0);
    do_snoop(2'd2, 6'h03);              // R8 invalid line
    cpu_op(1'b1, 6'h03, 8'h77, 1'b0);
    cpu_op(1'b0, 6'h13, 8'h00, 1'b1);   // R10 snoop cancels waiting write-back

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] a;
      a = {AW-IW'($urandom_range(0, 2)), IW'($urandom_range(0, NL - 1))};
      if ($urandom_range(0, 9) < 3)
        do_snoop(2'($urandom_range(1, 2)), a);
      else
        cpu_op(1'($urandom_range(0, 1)), a, DW'($urandom), 1'($urandom_range(0, 7) == 0));
    end
    summary();
  end
endmodule